// File: doc/BRIEF.md
# Leapfrog Two-Stage Tap Decoder

This block holds the digital selection logic of a two-stage segmented string converter. A code is captured on a load strobe. Its upper byte names one of 256 segments on a coarse resistor string. The lower byte names one of 256 taps on a fine string, which is stretched between the two ends of that segment.

Two buffers span the chosen segment. They do not keep fixed bottom and top roles. Buffer A serves every even coarse tap and buffer B serves every odd coarse tap. When the code steps into the next segment, the buffer on the shared tap stays where it is, and the other buffer jumps two taps to become the new far end.

Because the lower end of the segment alternates between the buffers, the block also drives an orientation flag. When the flag is set, the fine-tap select is mirrored, so that the analog output still rises with the code in offset-binary order: code zero gives the bottom of the range and all ones gives the top.

Top module: `leapfrog_tap_dec`

## Requirements
- R1: After reset, buffer A selects coarse tap 0, buffer B selects coarse tap 1, the fine select is tap 0 and the orientation flag is 0.
- R2: The selects and the flag change only in the clock cycle after `load` is high. With `load` low, a changing `code` has no effect.
- R3: For segment s = code[15:8], the two buffers together select coarse taps s and s+1. Buffer A only ever selects an even tap and buffer B only ever selects an odd tap.
- R4: `tap_a`, `tap_b` and `tap_fine` each have exactly one bit set. Bit i of `tap_a` or `tap_b` means coarse tap i. Bit j of `tap_fine` means fine tap j.
- R5: `flip` is 1 exactly when s is odd, that is, when buffer B holds the lower tap of the segment.
- R6: The selected fine tap index is code[7:0] when `flip` is 0, and 255 minus code[7:0] when `flip` is 1.
- R7: When the segment index rises by one, and the new segment is not segment 0, one buffer keeps its tap and the other buffer moves up by exactly two taps.
- R8: The effective position equals the registered code, and it rises strictly as the code rises. The effective position is (lower coarse tap) × 256 + (fine index, un-mirrored when `flip` is 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Capture `code` at the next clock edge |
| code | input | 16 | Offset-binary input code |
| tap_a | output | 257 | One-hot coarse tap select for buffer A (even taps) |
| tap_b | output | 257 | One-hot coarse tap select for buffer B (odd taps) |
| tap_fine | output | 256 | One-hot fine tap select |
| flip | output | 1 | 1 when buffer B holds the segment's lower end |

## Verification
The main stimulus is an ascending sweep over all 65,536 codes, loaded one per cycle. This sweep covers both orientations in every segment and all 255 boundary crossings. It separates a correct leapfrog from a fixed bottom/top assignment, because that assignment would move both buffers at a boundary. It also separates a correct mirror from a missing one, because without the mirror the position would fall inside every odd segment.

A hold pattern then drives new codes with `load` low. This shows that the selects are tied to the strobe and not to the live input. The wrap from segment 255 back to segment 0 is checked on its own, so that the two-tap jump rule is not applied there.

// File: rtl/leapfrog_tap_dec.sv
module leapfrog_tap_dec #(
  parameter int CW = 8,
  parameter int FW = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [CW+FW-1:0]      code,
  output logic [(1<<CW):0]      tap_a,
  output logic [(1<<CW):0]      tap_b,
  output logic [(1<<FW)-1:0]    tap_fine,
  output logic                  flip
);
  localparam int NTAP  = (1 << CW) + 1;
  localparam int NFINE = 1 << FW;
  localparam int W     = CW + FW;

  logic [W-1:0]  code_q;
  logic [CW-1:0] seg;
  logic [FW-1:0] fine_code, fine_idx;
  logic [CW:0]   lo_tap, hi_tap, a_idx, b_idx;

  always_ff @(posedge clk) begin
    if (!rst_n)    code_q <= '0;
    else if (load) code_q <= code;
  end

  assign seg       = code_q[W-1:FW];
  assign fine_code = code_q[FW-1:0];
  assign lo_tap    = {1'b0, seg};
  assign hi_tap    = lo_tap + 1'b1;
  assign flip      = seg[0];
  assign a_idx     = flip ? hi_tap : lo_tap;
  assign b_idx     = flip ? lo_tap : hi_tap;
  assign fine_idx  = flip ? ~fine_code : fine_code;

  assign tap_a    = {{(NTAP-1){1'b0}}, 1'b1} << a_idx;
  assign tap_b    = {{(NTAP-1){1'b0}}, 1'b1} << b_idx;
  assign tap_fine = {{(NFINE-1){1'b0}}, 1'b1} << fine_idx;

  AST_A_ONEHOT:    assert property (@(posedge clk) disable iff (!rst_n) $countones(tap_a) == 1); // R4
  AST_B_ONEHOT:    assert property (@(posedge clk) disable iff (!rst_n) $countones(tap_b) == 1); // R4
  AST_FINE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $countones(tap_fine) == 1); // R4
  AST_ADJACENT:    assert property (@(posedge clk) disable iff (!rst_n)
                     flip ? (tap_a == (tap_b << 1)) : (tap_b == (tap_a << 1))); // R5
  AST_HOLD:        assert property (@(posedge clk) disable iff (!rst_n)
                     !load |=> ($stable(tap_a) && $stable(tap_b) && $stable(tap_fine) && $stable(flip))); // R2
  AST_LEAPFROG:    assert property (@(posedge clk) disable iff (!rst_n)
                     (seg != '0 && seg == $past(seg) + 1'b1) |-> ($stable(tap_a) || $stable(tap_b))); // R7
endmodule

// File: tb/leapfrog_tap_dec_tb.sv
module leapfrog_tap_dec_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         load = 1'b0;
  logic [15:0]  code = '0;
  logic [256:0] tap_a, tap_b;
  logic [255:0] tap_fine;
  logic         flip;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  leapfrog_tap_dec u_dut (
    .clk(clk), .rst_n(rst_n), .load(load), .code(code),
    .tap_a(tap_a), .tap_b(tap_b), .tap_fine(tap_fine), .flip(flip)
  );

  function automatic int idx_of(input logic [256:0] v);
    for (int i = 0; i < 257; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_code(input int c);
    int s, a, b, f, lo, eff;
    s  = c >> 8;
    a  = idx_of(tap_a);
    b  = idx_of(tap_b);
    f  = idx_of({1'b0, tap_fine});
    chk($countones(tap_a) == 1 && $countones(tap_b) == 1 && $countones(tap_fine) == 1,
        "R4 one-hot", $countones(tap_a) + $countones(tap_b) + $countones(tap_fine), 3);
    chk(a % 2 == 0 && b % 2 == 1, "R3 parity", a * 1000 + b, 0);
    lo = (a < b) ? a : b;
    chk(lo == s && ((a > b) ? a : b) == s + 1, "R3 span", lo, s);
    chk(flip == (s % 2), "R5 flip", flip, s % 2);
    chk(f == ((s % 2) ? 255 - (c & 255) : (c & 255)), "R6 fine", f, (s % 2) ? 255 - (c & 255) : (c & 255));
    eff = lo * 256 + (flip ? 255 - f : f);
    chk(eff == c, "R8 position", eff, c);
  endtask

  initial begin
    int pa, pb, prev_eff, a, b, eff;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tap_a == 257'd1, "R1 reset tap_a", idx_of(tap_a), 0);
    chk(tap_b == 257'd2, "R1 reset tap_b", idx_of(tap_b), 1);
    chk(tap_fine == 256'd1 && flip == 1'b0, "R1 reset fine/flip", idx_of({1'b0, tap_fine}), 0);

    prev_eff = -1; pa = 0; pb = 1;
    for (int c = 0; c < 65536; c++) begin
      code = c[15:0]; load = 1'b1;
      @(negedge clk);
      check_code(c);
      a = idx_of(tap_a); b = idx_of(tap_b);
      eff = ((a < b) ? a : b) * 256 + (flip ? 255 - idx_of({1'b0, tap_fine}) : idx_of({1'b0, tap_fine}));
      chk(eff > prev_eff, "R8 monotonic", eff, prev_eff + 1);
      if (c > 0 && (c & 255) == 0)
        chk((a == pa && b == pb + 2) || (b == pb && a == pa + 2), "R7 leapfrog", a * 1000 + b, pa * 1000 + pb);
      prev_eff = eff; pa = a; pb = b;
    end

    load = 1'b0;
    for (int k = 0; k < 4; k++) begin
      code = 16'h1234 + 16'(k * 999);
      @(negedge clk);
      chk(idx_of(tap_a) == 256 && idx_of(tap_b) == 255 && flip && tap_fine == 256'd1,
          "R2 hold", idx_of(tap_a), 256);
    end

    code = 16'h0000; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    chk(tap_a == 257'd1 && tap_b == 257'd2 && !flip, "R3 wrap to segment 0", idx_of(tap_a), 0);
    code = 16'h0100; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    chk(idx_of(tap_a) == 2 && idx_of(tap_b) == 1 && flip && tap_fine == (256'd1 << 255),
        "R6 first odd segment", idx_of({1'b0, tap_fine}), 255);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule